// File: doc/BRIEF.md
# Dual-Select Serial Register and Byte Port

This block is the slave end of a three-wire serial bus (clock, data in, data out) that two active-low selects share. With the configuration select low, the master reaches a small register file. Each pair of bytes forms one access: a header byte that names a register and its direction, then a data byte. On a write the data byte is stored. On a read the master clocks in a zero byte, and the block shifts the register value out on the data-out line. The select may stay low for any number of such pairs. With the payload select low, the block moves exactly one byte. It takes a byte from an external FIFO when the select falls and shifts that byte out. It hands each received byte to the FIFO with a one-cycle push strobe.

All serial inputs are brought into the system clock domain through a synchronizer, and the edges of the serial clock are detected there. The serial clock must therefore stay high and stay low for at least SYNC_STAGES+2 system clock periods in each phase. The register contents are exported as one flat vector for the rest of the design. The data-out enable is formed directly from the two select pins, so the pad is released as soon as both selects are high.

Top module: `spi2cs_port`

## Requirements
- R1: After reset all registers read as zero, no push or pop strobe is issued, and the data-out enable is low while both selects are high.
- R2: miso_oe is high exactly when at least one of cfg_cs_n and dat_cs_n is low, in every cycle.
- R3: Bits travel MSB first. The block samples mosi on the rising edge of sck and changes miso after the falling edge. Header byte layout: bit 7 is a start bit that must be 0, bit 6 is the direction (1 = read), bits 5..1 are the register address, and bit 0 is a stop bit that must be 1.
- R4: A write header followed by a data byte stores that data byte in the addressed register.
- R5: While cfg_cs_n stays low, bytes keep alternating between header and data, so several accesses can run back to back, and a read sees a write made earlier in the same select.
- R6: On a read, the data byte clocked out on miso is the register value. The byte the master sends meanwhile writes nothing. miso carries zeros during every header byte.
- R7: If a header has a start bit of 1 or a stop bit of 0, the data byte after it writes nothing and reads back as zero. The following byte is still taken as a header.
- R8: An address at or above NUM_REGS is not written, and a read from it returns zero.
- R9: If the select rises part-way through a byte, the partial byte is dropped. The next transfer starts again with bit 7 of a header.
- R10: On the payload port, the eighth received bit gives one fifo_push pulse with the byte. Further bits under the same select are ignored until the select rises.
- R11: When dat_cs_n falls while cfg_cs_n is high, one fifo_pop pulse is issued. The fifo_rdata byte presented at that moment is shifted out MSB first.
- R12: While cfg_cs_n is low, the payload port is idle: a fall of dat_cs_n causes no pop, and bits give no push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| cfg_cs_n | input | 1 | Active-low select for register accesses |
| dat_cs_n | input | 1 | Active-low select for payload bytes |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for the miso pad |
| fifo_push | output | 1 | One-cycle strobe: received payload byte valid |
| fifo_push_data | output | 8 | Received payload byte |
| fifo_pop | output | 1 | One-cycle strobe: head of FIFO taken |
| fifo_rdata | input | 8 | Head byte of the transmit FIFO |
| regs_flat | output | NUM_REGS*8 | All register contents, register n at bits 8n+7..8n |

## Verification
Some properties are checked on every cycle by the assertions. A write landing in its register, an out-of-range write leaving the file unchanged, a pop starting from a cleared bit count, a push never following a cycle with the configuration port active, and the bit count clearing when the configuration select rises. The bench's scenarios show the rest, which only appears across whole transfers. This covers the header and data alternation, read data on miso, rejection of bad headers, dropped partial bytes, one byte per payload select, and the order of popped and pushed bytes. The drive-enable and register contents are also compared with a behavioural model on every clock.

// File: rtl/spi2cs_pkg.sv
package spi2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } cfg_phase_e;

  // header byte, MSB first on the wire
  typedef struct packed {
    logic              start;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic              stop;
  } hdr_byte_t;
endpackage

// File: rtl/spi2cs_sync.sv
module spi2cs_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi2cs_shift.sv
module spi2cs_shift #(
  parameter int BW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  en,
  input  logic                  sck_rise,
  input  logic                  sck_fall,
  input  logic                  mosi_i,
  input  logic                  load_en,
  input  logic [BW-1:0]         load_val,
  output logic [$clog2(BW)-1:0] bit_idx,
  output logic                  byte_done,
  output logic [BW-1:0]         rx_byte,
  output logic                  miso_o
);
  localparam int CW = $clog2(BW);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] rx_q, rx_d, tx_q, tx_d;

  always_comb begin
    cnt_d = cnt_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && sck_rise) begin
      cnt_d = (cnt_q == CW'(BW-1)) ? '0 : cnt_q + 1'b1;
      rx_d  = {rx_q[BW-2:0], mosi_i};
    end
    if (load_en) begin
      tx_d = load_val;
    end else if (en && sck_fall && cnt_q != '0) begin
      tx_d = {tx_q[BW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
    end
  end

  assign bit_idx   = cnt_q;
  assign byte_done = en && !clr && sck_rise && (cnt_q == CW'(BW-1));
  assign rx_byte   = {rx_q[BW-2:0], mosi_i};
  assign miso_o    = tx_q[BW-1];
endmodule

// File: rtl/spi2cs_regs.sv
module spi2cs_regs #(
  parameter int NUM_REGS = 20,
  parameter int DW       = 8,
  parameter int AW       = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [AW-1:0]          raddr,
  output logic [DW-1:0]          rdata,
  output logic [NUM_REGS*DW-1:0] regs_flat
);
  logic [DW-1:0] mem_q [NUM_REGS];
  logic [DW-1:0] mem_d [NUM_REGS];

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      mem_d[i] = (we && 32'(waddr) == i) ? wdata : mem_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= mem_d[i];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (32'(raddr) == i) rdata = mem_q[i];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = mem_q[g];

    // R4: a write reaches its register one cycle later
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && 32'(waddr) == g) |=> (regs_flat[g*DW +: DW] == $past(wdata)));
  end

  // R8: writes beyond the file change nothing
  p_oob_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && 32'(waddr) >= NUM_REGS) |=> $stable(regs_flat));
endmodule

// File: rtl/spi2cs_port.sv
module spi2cs_port
  import spi2cs_pkg::*;
#(
  parameter int NUM_REGS    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sck,
  input  logic                       mosi,
  input  logic                       cfg_cs_n,
  input  logic                       dat_cs_n,
  output logic                       miso,
  output logic                       miso_oe,
  output logic                       fifo_push,
  output logic [BYTE_W-1:0]          fifo_push_data,
  output logic                       fifo_pop,
  input  logic [BYTE_W-1:0]          fifo_rdata,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  localparam int CW = $clog2(BYTE_W);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // input synchronizer and edge detection
  logic [3:0] sync_q;
  logic [2:0] edg_q;
  logic       sck_s, mosi_s, cfg_s, dat_s;
  logic       sck_rise, sck_fall, cfg_start, dat_fall;

  spi2cs_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .din   ({sck, mosi, cfg_cs_n, dat_cs_n}),
    .q     (sync_q)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) edg_q <= 3'b011;
    else         edg_q <= {sync_q[3], sync_q[1:0]};
  end

  assign sck_s     = sync_q[3];
  assign mosi_s    = sync_q[2];
  assign cfg_s     = sync_q[1];
  assign dat_s     = sync_q[0];
  assign sck_rise  = sck_s & ~edg_q[2];
  assign sck_fall  = ~sck_s & edg_q[2];
  assign cfg_start = ~cfg_s & edg_q[1];
  assign dat_fall  = ~dat_s & edg_q[0];

  // framing state
  cfg_phase_e        phase_q, phase_d;
  hdr_byte_t         hdr_q, hdr_d;
  logic              dat_done_q, dat_done_d;
  logic              push_q, push_d, pop_q, pop_d;
  logic [BYTE_W-1:0] push_data_q, push_data_d;

  logic              cfg_sel, dat_sel, dat_start, active, clr;
  logic              hdr_ok, rd_phase, load_en, reg_we;
  logic [BYTE_W-1:0] load_val, rdata, rx_byte;
  logic [CW-1:0]     bit_idx;
  logic              byte_done, sh_miso;

  assign cfg_sel   = ~cfg_s;
  assign dat_sel   = ~dat_s & cfg_s;
  assign dat_start = dat_fall & cfg_s;
  assign active    = cfg_sel | (dat_sel & ~dat_done_q);
  assign clr       = ~active | cfg_start | dat_start;
  assign hdr_ok    = ~hdr_q.start & hdr_q.stop;
  assign rd_phase  = cfg_sel & (phase_q == PH_DATA) & hdr_ok & hdr_q.rd;
  assign load_en   = cfg_start | dat_start | (cfg_sel & sck_fall & (bit_idx == '0));
  assign load_val  = dat_start ? fifo_rdata : (rd_phase ? rdata : '0);
  assign reg_we    = cfg_sel & byte_done & (phase_q == PH_DATA) & hdr_ok & ~hdr_q.rd;

  always_comb begin
    phase_d     = phase_q;
    hdr_d       = hdr_q;
    dat_done_d  = dat_done_q;
    push_d      = dat_sel & byte_done;
    push_data_d = push_data_q;
    pop_d       = dat_start;
    if (!cfg_sel) begin
      phase_d = PH_ADDR;
    end else if (byte_done) begin
      phase_d = (phase_q == PH_ADDR) ? PH_DATA : PH_ADDR;
      if (phase_q == PH_ADDR) hdr_d = hdr_byte_t'(rx_byte);
    end
    if (!dat_sel)       dat_done_d = 1'b0;
    else if (byte_done) dat_done_d = 1'b1;
    if (push_d) push_data_d = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_ADDR;
      hdr_q       <= '0;
      dat_done_q  <= 1'b0;
      push_q      <= 1'b0;
      push_data_q <= '0;
      pop_q       <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      hdr_q       <= hdr_d;
      dat_done_q  <= dat_done_d;
      push_q      <= push_d;
      push_data_q <= push_data_d;
      pop_q       <= pop_d;
    end
  end

  spi2cs_shift #(.BW(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr       (clr),
    .en        (active),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .mosi_i    (mosi_s),
    .load_en   (load_en),
    .load_val  (load_val),
    .bit_idx   (bit_idx),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso_o    (sh_miso)
  );

  spi2cs_regs #(.NUM_REGS(NUM_REGS), .DW(BYTE_W), .AW(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_ni),
    .we        (reg_we),
    .waddr     (hdr_q.addr),
    .wdata     (rx_byte),
    .raddr     (hdr_q.addr),
    .rdata     (rdata),
    .regs_flat (regs_flat)
  );

  assign miso           = sh_miso;
  assign miso_oe        = ~cfg_cs_n | ~dat_cs_n;
  assign fifo_push      = push_q;
  assign fifo_push_data = push_data_q;
  assign fifo_pop       = pop_q;

  // R12: a push never follows a cycle in which the register port owned the bus
  p_push_not_cfg_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    fifo_push |-> !$past(cfg_sel));

  // R11: a popped byte starts from a cleared bit count
  p_pop_clean_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    fifo_pop |-> (bit_idx == '0));

  // R9: releasing the register select with no payload select drops the partial byte
  p_cfg_release_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_s && !edg_q[1] && dat_s) |=> (bit_idx == '0));
endmodule

// File: tb/spi2cs_port_tb_top.sv
`timescale 1ns/1ps
module spi2cs_port_tb_top;
  localparam int NR = 20;
  localparam int H  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, cfg_cs_n = 1'b1, dat_cs_n = 1'b1;
  logic [7:0] fifo_rdata = 8'h00;
  logic miso, miso_oe, fifo_push, fifo_pop;
  logic [7:0] fifo_push_data;
  logic [NR*8-1:0] regs_flat;

  always #2.5 clk = ~clk;

  spi2cs_port #(.NUM_REGS(NR), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi),
    .cfg_cs_n(cfg_cs_n), .dat_cs_n(dat_cs_n),
    .miso(miso), .miso_oe(miso_oe),
    .fifo_push(fifo_push), .fifo_push_data(fifo_push_data),
    .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
    .regs_flat(regs_flat)
  );

  int tests = 0, fails = 0;
  bit quiet = 1'b1;
  logic [7:0] mdl [NR];
  logic [7:0] push_log[$], pop_src[$], pop_log[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R2", "miso_oe", int'(miso_oe), int'(!cfg_cs_n || !dat_cs_n));
      if (fifo_push) push_log.push_back(fifo_push_data);
      if (fifo_pop) pop_log.push_back(pop_src.size() > 0 ? pop_src.pop_front() : 8'h00);
      if (quiet) begin
        for (int g = 0; g < NR; g++) chk("R4", $sformatf("reg%0d", g), int'(regs_flat[g*8 +: 8]), int'(mdl[g]));
      end
    end
    fifo_rdata = (pop_src.size() > 0) ? pop_src[0] : 8'h00;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tb, input int n, output logic [7:0] rb);
    rb = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tb[i];
      tick(H);
      rb[i] = miso;
      sck = 1'b1;
      tick(H);
      sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tb, output logic [7:0] rb);
    xbits(tb, 8, rb);
  endtask

  task automatic cfg_begin();
    quiet = 1'b0;
    cfg_cs_n = 1'b0;
    tick(2*H);
  endtask

  task automatic cfg_end();
    tick(H);
    cfg_cs_n = 1'b1;
    tick(8);
    quiet = 1'b1;
  endtask

  function automatic logic [7:0] hb(input bit rd, input int a);
    return {1'b0, rd, 5'(a), 1'b1};
  endfunction

  initial begin
    logic [7:0] r;
    for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
    pop_src.push_back(8'h9A);
    pop_src.push_back(8'h6B);
    tick(4);
    rst_n = 1'b1;
    tick(6);
    chk("R1", "regs after reset", int'(regs_flat == '0), 1);
    chk("R1", "push after reset", int'(fifo_push), 0);
    chk("R1", "pop after reset", int'(fifo_pop), 0);
    chk("R1", "miso_oe idle", int'(miso_oe), 0);

    // R3/R4: single write
    cfg_begin();
    xbyte(hb(0, 3), r);
    xbyte(8'hA5, r);
    mdl[3] = 8'hA5;
    cfg_end();
    chk("R3", "reg3 via header", int'(regs_flat[3*8 +: 8]), 8'hA5);

    // R6: read back
    cfg_begin();
    xbyte(hb(1, 3), r);
    chk("R6", "miso during header", r, 0);
    xbyte(8'h00, r);
    chk("R6", "read data reg3", r, 8'hA5);
    cfg_end();

    // R5: back-to-back accesses under one select
    cfg_begin();
    xbyte(hb(0, 0), r);  xbyte(8'h11, r);
    xbyte(hb(0, 19), r); xbyte(8'hC3, r);
    xbyte(hb(0, 7), r);  xbyte(8'h5A, r);
    mdl[0] = 8'h11; mdl[19] = 8'hC3; mdl[7] = 8'h5A;
    xbyte(hb(1, 19), r);
    xbyte(8'h00, r);
    chk("R5", "read after write same select", r, 8'hC3);
    cfg_end();

    // R8: out-of-range address
    cfg_begin();
    xbyte(hb(0, 25), r); xbyte(8'hFF, r);
    xbyte(hb(1, 25), r); xbyte(8'h00, r);
    chk("R8", "read addr 25", r, 0);
    xbyte(hb(1, 20), r); xbyte(8'h00, r);
    chk("R8", "read addr 20", r, 0);
    cfg_end();

    // R7: malformed headers
    cfg_begin();
    xbyte({1'b1, 1'b0, 5'd7, 1'b1}, r); xbyte(8'h77, r);
    xbyte({1'b0, 1'b0, 5'd7, 1'b0}, r); xbyte(8'h77, r);
    xbyte({1'b1, 1'b1, 5'd7, 1'b1}, r); xbyte(8'h00, r);
    chk("R7", "read with bad header", r, 0);
    xbyte(hb(0, 8), r); xbyte(8'h81, r);
    mdl[8] = 8'h81;
    xbyte(hb(1, 7), r); xbyte(8'h00, r);
    chk("R7", "reg7 untouched", r, 8'h5A);
    cfg_end();

    // R9: partial header, then partial data byte
    cfg_begin();
    xbits(hb(0, 2), 4, r);
    cfg_end();
    cfg_begin();
    xbyte(hb(0, 2), r); xbyte(8'h42, r);
    mdl[2] = 8'h42;
    cfg_end();
    chk("R9", "reg2 after restart", int'(regs_flat[2*8 +: 8]), 8'h42);
    cfg_begin();
    xbyte(hb(0, 1), r);
    xbits(8'hEE, 5, r);
    cfg_end();
    chk("R9", "reg1 after partial data", int'(regs_flat[1*8 +: 8]), 0);

    // R10/R11: payload port
    dat_cs_n = 1'b0;
    tick(2*H);
    xbyte(8'h3C, r);
    chk("R11", "first popped byte on miso", r, 8'h9A);
    xbyte(8'hE7, r);
    tick(H);
    dat_cs_n = 1'b1;
    tick(8);
    chk("R10", "push count", push_log.size(), 1);
    chk("R10", "pushed byte", push_log.size() > 0 ? int'(push_log[0]) : -1, 8'h3C);
    chk("R11", "pop count", pop_log.size(), 1);
    dat_cs_n = 1'b0;
    tick(2*H);
    xbyte(8'hD2, r);
    chk("R11", "second popped byte on miso", r, 8'h6B);
    tick(H);
    dat_cs_n = 1'b1;
    tick(8);
    chk("R10", "push count 2", push_log.size(), 2);
    chk("R10", "second pushed byte", push_log.size() > 1 ? int'(push_log[1]) : -1, 8'hD2);
    chk("R11", "pop count 2", pop_log.size(), 2);

    // R12: both selects low, register port wins
    quiet = 1'b0;
    cfg_cs_n = 1'b0;
    dat_cs_n = 1'b0;
    tick(2*H);
    xbyte(hb(0, 5), r); xbyte(8'h99, r);
    mdl[5] = 8'h99;
    tick(H);
    cfg_cs_n = 1'b1;
    tick(4);
    dat_cs_n = 1'b1;
    tick(8);
    quiet = 1'b1;
    chk("R12", "no push while cfg owns bus", push_log.size(), 2);
    chk("R12", "no pop while cfg owns bus", pop_log.size(), 2);
    chk("R12", "cfg write under both selects", int'(regs_flat[5*8 +: 8]), 8'h99);

    tick(4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule